// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is an SPI bus master that runs a complete multi-word transaction from a small preloaded queue, with no host involvement once the transaction has started. The host writes outgoing words into a transmit memory and per-transfer control words into a command memory. It then sets the first and last queue index and issues a start. The block works through every entry in that range in turn. For each entry it drives the four chip-select lines from that entry's command word and shifts the word out on MOSI, most significant bit first, in SPI mode 0. At the same time it captures MISO into a receive memory slot with the same index.

A typical read sends a few request words and then some all-zero filler words. The filler words give the slave the clock edges it needs to return its answer, which the host collects from the receive memory once the done flag rises. Each command entry can hold chip select active into the next entry. The resting level of every select line can be set separately, so active-high and active-low slaves can share the bus. A programmable pause between transfers gives slow slaves time to prepare.

Top module: `spi_queue_master`

## Requirements
- R1: After reset, every select line rests at high (the idle-level register resets to all ones), SCK is low, the done output is low, and the status word (address 0x34) reads 0.
- R2: A write of 1 to bit 0 of address 0x34 runs queue entries from the start index to the end index (address 0x32, start in bits [3:0], end in bits [7:4]) in ascending order. Each transfer is full duplex, and the word received during entry i is readable at address 0x20+i. Transmit words are written at 0x00+i and command words at 0x10+i.
- R3: While an entry is shifting, select line k is at the inverse of its idle level when bit k of the command word (bits [3:0]) is set, and at its idle level otherwise.
- R4: The idle level of each select line is bit k of address 0x33. Lines not selected by the running entry, and all lines when no transaction runs, sit at that level.
- R5: When command bit 4 is set, the entry's select pattern is held with no idle-level cycle until the next entry begins. When it is clear, all lines return to idle for at least one cycle between transfers.
- R6: Command bit 5 set gives a 16-bit transfer of the whole transmit word. Clear gives an 8-bit transfer of bits [7:0], with the received byte stored in bits [7:0] and bits [15:8] zero. Bits go out MSB first in mode 0: MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R7: SCK stays high for BAUD system clocks and low for BAUD system clocks, where BAUD is address 0x30 (reset value 1). A BAUD of 0 behaves as 1.
- R8: From the last falling SCK edge of one entry to the first rising edge of the next, exactly BAUD + 2 + GAP system clocks pass, where GAP is address 0x31.
- R9: After the last entry, the done output and status bit 0 rise and stay set. Status bit 1 (busy) clears and all select lines return to idle, whatever the last entry's bit 4 says. A write of 1 to bit 1 of address 0x34 clears done.
- R10: A start written while a transaction is running is ignored: no extra transfer follows.
- R11: An all-zero transmit word holds MOSI low for its whole transfer while the response is still captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from host_addr |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| sel_out | output | 4 | Peripheral select lines |
| queue_done | output | 1 | Sticky end-of-queue flag |

## Verification
The queue is run with three contrasting patterns. The first is 16-bit entries that hold select across entries at a divider of 2 with no pause. The second is 8-bit entries that release select between transfers, using mixed idle polarities, a divider of 1 and a three-clock pause. The third is a single zero-filled 16-bit entry with a divider of 0 and a start repeated mid-transfer. The first two separate the hold-versus-release behaviour of the continue bit and the word-versus-byte alignment of both the transmit and the receive paths. The inter-transfer spacing is measured under two divider and pause settings, so the BAUD and GAP terms cannot be confused with each other. The last pattern separates a zero divider from a stalled clock and shows that a second start adds no transfer. A slave model drives MISO from a known bit stream, so every received word is predicted bit for bit.

// File: rtl/spi_qm_pkg.sv
package spi_qm_pkg;
  localparam int WORD_W = 16;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_RUN, SQ_GAP} sq_state_t;

  // host address regions (upper two address bits)
  localparam logic [1:0] RG_TX  = 2'd0;
  localparam logic [1:0] RG_CMD = 2'd1;
  localparam logic [1:0] RG_RX  = 2'd2;
  localparam logic [1:0] RG_CFG = 2'd3;

  // slots inside the configuration region
  localparam int CFG_BAUD = 0;
  localparam int CFG_GAP  = 1;
  localparam int CFG_PTR  = 2;
  localparam int CFG_IDLE = 3;
  localparam int CFG_CTRL = 4;

  // number of bits moved by one entry
  function automatic int unsigned xfer_len(input logic wide);
    return wide ? WORD_W : HALF_W;
  endfunction
endpackage

// File: rtl/spi_qm_store.sv
module spi_qm_store
  import spi_qm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NCS   = 4,
  parameter int CNT_W = 8,
  parameter int IDX_W = 4,
  parameter int HA_W  = 6,
  parameter int CMD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] tx_word,
  output logic [CMD_W-1:0]  cmd_word,
  input  logic              rx_we,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic [WORD_W-1:0] rx_data,
  input  logic              busy,
  input  logic              done,
  output logic [CNT_W-1:0]  baud,
  output logic [CNT_W-1:0]  gap,
  output logic [IDX_W-1:0]  start_ptr,
  output logic [IDX_W-1:0]  end_ptr,
  output logic [NCS-1:0]    idle_lvl,
  output logic              start_req,
  output logic              clr_done
);
  logic [WORD_W-1:0] tx_mem  [DEPTH];
  logic [CMD_W-1:0]  cmd_mem [DEPTH];
  logic [WORD_W-1:0] rx_mem  [DEPTH];

  logic [1:0]       region;
  logic [IDX_W-1:0] slot;
  logic             ctrl_wr;

  assign region  = host_addr[HA_W-1:IDX_W];
  assign slot    = host_addr[IDX_W-1:0];
  assign ctrl_wr = host_we && region == RG_CFG && slot == IDX_W'(CFG_CTRL);

  assign start_req = ctrl_wr && host_wdata[0];
  assign clr_done  = ctrl_wr && host_wdata[1];

  assign tx_word  = tx_mem[rd_idx];
  assign cmd_word = cmd_mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tx_mem[i]  <= '0;
        cmd_mem[i] <= '0;
      end
      baud      <= CNT_W'(1);
      gap       <= '0;
      start_ptr <= '0;
      end_ptr   <= '0;
      idle_lvl  <= '1;
    end else if (host_we) begin
      case (region)
        RG_TX:  tx_mem[slot]  <= host_wdata;
        RG_CMD: cmd_mem[slot] <= host_wdata[CMD_W-1:0];
        RG_CFG: begin
          if (slot == IDX_W'(CFG_BAUD)) baud <= host_wdata[CNT_W-1:0];
          if (slot == IDX_W'(CFG_GAP))  gap  <= host_wdata[CNT_W-1:0];
          if (slot == IDX_W'(CFG_PTR)) begin
            start_ptr <= host_wdata[IDX_W-1:0];
            end_ptr   <= host_wdata[2*IDX_W-1:IDX_W];
          end
          if (slot == IDX_W'(CFG_IDLE)) idle_lvl <= host_wdata[NCS-1:0];
        end
        default: ;
      endcase
    end
  end

  // receive memory has a single writer: the sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rx_mem[i] <= '0;
    end else if (rx_we) begin
      rx_mem[rx_idx] <= rx_data;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (region)
      RG_TX:  host_rdata = tx_mem[slot];
      RG_CMD: host_rdata = WORD_W'(cmd_mem[slot]);
      RG_RX:  host_rdata = rx_mem[slot];
      default: begin
        if (slot == IDX_W'(CFG_BAUD)) host_rdata = WORD_W'(baud);
        if (slot == IDX_W'(CFG_GAP))  host_rdata = WORD_W'(gap);
        if (slot == IDX_W'(CFG_PTR))  host_rdata = WORD_W'({end_ptr, start_ptr});
        if (slot == IDX_W'(CFG_IDLE)) host_rdata = WORD_W'(idle_lvl);
        if (slot == IDX_W'(CFG_CTRL)) host_rdata = WORD_W'({busy, done});
      end
    endcase
  end
endmodule

// File: rtl/spi_qm_shifter.sv
module spi_qm_shifter
  import spi_qm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              wide,
  input  logic [WORD_W-1:0] tx_word,
  input  logic [CNT_W-1:0]  baud,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              fin,
  output logic [WORD_W-1:0] rx_word
);
  localparam int BITS_W = $clog2(WORD_W) + 1;

  logic              active, sck_q, wide_q, fin_q;
  logic [WORD_W-1:0] tx_sh, rx_sh;
  logic [CNT_W-1:0]  cnt, half_m1;
  logic [BITS_W-1:0] left;
  logic              tick, sck_rise, sck_fall;

  // a zero divider behaves as one
  assign half_m1  = (baud == '0) ? '0 : baud - 1'b1;
  assign tick     = active && cnt == half_m1;
  assign sck_rise = tick && !sck_q;
  assign sck_fall = tick && sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sck_q  <= 1'b0;
      wide_q <= 1'b0;
      fin_q  <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      cnt    <= '0;
      left   <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        active <= 1'b1;
        sck_q  <= 1'b0;
        cnt    <= '0;
        wide_q <= wide;
        tx_sh  <= wide ? tx_word : {tx_word[HALF_W-1:0], {HALF_W{1'b0}}};
        rx_sh  <= '0;
        left   <= BITS_W'(xfer_len(wide));
      end else if (active) begin
        if (tick) begin
          cnt <= '0;
          if (sck_rise) begin
            sck_q <= 1'b1;
            rx_sh <= {rx_sh[WORD_W-2:0], miso};
          end else begin
            sck_q <= 1'b0;
            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            left  <= left - 1'b1;
            if (left == BITS_W'(1)) begin
              active <= 1'b0;
              fin_q  <= 1'b1;
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign sck     = sck_q;
  assign mosi    = active & tx_sh[WORD_W-1];
  assign fin     = fin_q;
  assign rx_word = wide_q ? rx_sh : {{HALF_W{1'b0}}, rx_sh[HALF_W-1:0]};

  // R6: data out is steady for the whole high phase of SCK
  a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(mosi));
  // R7: the clock only moves while a word is shifting
  a_r7_sck_low_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sck_q);
  // R6: a word ends on a falling edge, never with SCK high
  a_r6_fin_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (!sck_q && !active));
endmodule

// File: rtl/spi_qm_seq.sv
module spi_qm_seq
  import spi_qm_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int NCS   = 4,
  parameter int CNT_W = 8,
  parameter int CMD_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             clr_done,
  input  logic [IDX_W-1:0] start_ptr,
  input  logic [IDX_W-1:0] end_ptr,
  input  logic [CNT_W-1:0] gap,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             fin,
  output logic [IDX_W-1:0] idx,
  output logic             go,
  output logic             wide,
  output logic [NCS-1:0]   cs_sel,
  output logic             rx_we,
  output logic             busy,
  output logic             done
);
  sq_state_t        state;
  logic [CNT_W-1:0] gcnt;
  logic             keep, last_entry;
  logic [NCS-1:0]   sel;

  assign sel        = cmd_word[NCS-1:0];
  assign keep       = cmd_word[NCS];
  assign wide       = cmd_word[NCS+1];
  assign last_entry = idx == end_ptr;
  assign go         = state == SQ_LOAD;
  assign rx_we      = state == SQ_RUN && fin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      idx    <= '0;
      cs_sel <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      gcnt   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start_req) begin
            idx   <= start_ptr;
            busy  <= 1'b1;
            done  <= 1'b0;
            state <= SQ_LOAD;
          end else if (clr_done) begin
            done <= 1'b0;
          end
        end
        SQ_LOAD: begin
          cs_sel <= sel;
          state  <= SQ_RUN;
        end
        SQ_RUN: begin
          if (fin) begin
            if (last_entry) begin
              cs_sel <= '0;
              busy   <= 1'b0;
              done   <= 1'b1;
              state  <= SQ_IDLE;
            end else begin
              idx <= idx + 1'b1;
              if (!keep) cs_sel <= '0;
              if (gap == '0) begin
                state <= SQ_LOAD;
              end else begin
                gcnt  <= gap;
                state <= SQ_GAP;
              end
            end
          end
        end
        default: begin
          if (gcnt == CNT_W'(1)) state <= SQ_LOAD;
          else gcnt <= gcnt - 1'b1;
        end
      endcase
    end
  end

  // R9: done and busy never overlap
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R9: no line is selected outside a transaction
  a_r9_released_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_sel == '0);
  // R2: the shifter completes words only while an entry is running
  a_r2_fin_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> state == SQ_RUN);
  // R10: a start during a transfer leaves the queue position alone
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_RUN && !fin && start_req) |=> (state == SQ_RUN && $stable(idx)));
endmodule

// File: rtl/spi_queue_master.sv
module spi_queue_master
  import spi_qm_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NCS   = 4,
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [5:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic [3:0]  sel_out,
  output logic        queue_done
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int HA_W  = IDX_W + 2;
  localparam int CMD_W = NCS + 2;

  logic [IDX_W-1:0]  idx, start_ptr, end_ptr;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [CMD_W-1:0]  cmd_word;
  logic [CNT_W-1:0]  baud, gap;
  logic [NCS-1:0]    idle_lvl, cs_sel;
  logic              start_req, clr_done, go, wide, fin, rx_we, busy, done;

  spi_qm_store #(
    .DEPTH(DEPTH), .NCS(NCS), .CNT_W(CNT_W),
    .IDX_W(IDX_W), .HA_W(HA_W), .CMD_W(CMD_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rd_idx(idx), .tx_word(tx_word), .cmd_word(cmd_word),
    .rx_we(rx_we), .rx_idx(idx), .rx_data(rx_word),
    .busy(busy), .done(done),
    .baud(baud), .gap(gap), .start_ptr(start_ptr), .end_ptr(end_ptr),
    .idle_lvl(idle_lvl), .start_req(start_req), .clr_done(clr_done)
  );

  spi_qm_seq #(
    .IDX_W(IDX_W), .NCS(NCS), .CNT_W(CNT_W), .CMD_W(CMD_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .clr_done(clr_done),
    .start_ptr(start_ptr), .end_ptr(end_ptr), .gap(gap),
    .cmd_word(cmd_word), .fin(fin),
    .idx(idx), .go(go), .wide(wide), .cs_sel(cs_sel),
    .rx_we(rx_we), .busy(busy), .done(done)
  );

  spi_qm_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .go(go), .wide(wide), .tx_word(tx_word), .baud(baud), .miso(miso),
    .sck(sck), .mosi(mosi), .fin(fin), .rx_word(rx_word)
  );

  // a selected line drives the opposite of its resting level
  for (genvar k = 0; k < NCS; k++) begin : g_sel
    assign sel_out[k] = idle_lvl[k] ^ cs_sel[k];
  end

  assign queue_done = done;

  // R4: with nothing running, every line rests at its programmed level
  a_r4_lines_rest_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sel_out == idle_lvl);
endmodule

// File: tb/spi_queue_master_bench.sv
`timescale 1ns/1ps
module spi_queue_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        miso = 1'b0;
  wire  [15:0] host_rdata;
  wire         sck, mosi, queue_done;
  wire  [3:0]  sel_out;

  always #2 clk = ~clk;

  spi_queue_master u_spi_queue_master (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .sel_out(sel_out), .queue_done(queue_done)
  );

  typedef struct {
    logic       m;
    logic [3:0] cs;
    bit         first;
    bit         chk;
  } bit_item_t;

  bit_item_t   exp_q[$];
  logic [15:0] rx_exp [16];
  int tests = 0, fails = 0, cyc = 0, last_rise = 0, last_fall = 0;
  int exp_half = 1, exp_gap = 0, rise_count = 0, idle_cycles = 0, mptr = 0, tally = 0;
  logic       sck_d = 1'b0;
  logic [3:0] idle_val = 4'hF;
  bit         seen_rise = 0;
  bit         finished = 0;

  localparam logic [5:0] A_BAUD = 6'h30, A_GAP = 6'h31, A_PTR = 6'h32;
  localparam logic [5:0] A_IDLE = 6'h33, A_CTRL = 6'h34;

  // slave response stream: a fixed, irregular bit pattern
  function automatic logic miso_bit(input int k);
    return logic'(((k ^ (k >> 2) ^ (k >> 3)) & 1) != 0);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected bit per rising SCK edge
  always @(negedge clk) begin
    bit_item_t it;
    cyc++;
    if (sck && !sck_d) begin
      rise_count++;
      if (exp_q.size() == 0) begin
        check(0, "R10 unexpected SCK rise", 1, 0);
      end else begin
        it = exp_q.pop_front();
        check(mosi === it.m, "R6 MOSI bit", longint'(mosi), longint'(it.m));
        check(sel_out === it.cs, "R3 select pattern", longint'(sel_out), longint'(it.cs));
        if (it.chk)
          check(cyc - last_fall == exp_gap, "R8 spacing", cyc - last_fall, exp_gap);
      end
      last_rise = cyc;
      seen_rise = 1;
    end
    if (!sck && sck_d) begin
      check(cyc - last_rise == exp_half, "R7 SCK high time", cyc - last_rise, exp_half);
      last_fall = cyc;
      mptr++;
      miso = miso_bit(mptr);
    end
    if (seen_rise && exp_q.size() > 0 && sel_out == idle_val) idle_cycles++;
    sck_d = sck;
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  // driver: loads one entry and queues what it must produce
  task automatic push_entry(input int idx, input logic [15:0] tx, input logic [3:0] sel,
                            input bit keep, input bit wide, input bit chk);
    bit_item_t   it;
    int          n;
    logic [15:0] w;
    n = wide ? 16 : 8;
    wr(6'(idx), tx);
    wr(6'h10 + 6'(idx), {10'd0, wide, keep, sel});
    for (int j = 0; j < n; j++) begin
      it.m     = wide ? tx[15-j] : tx[7-j];
      it.cs    = idle_val ^ sel;
      it.first = (j == 0);
      it.chk   = chk && (j == 0);
      exp_q.push_back(it);
    end
    w = '0;
    for (int j = 0; j < n; j++) w = {w[14:0], miso_bit(tally + j)};
    tally += n;
    rx_exp[idx] = w;
  endtask

  task automatic wait_done();
    logic [15:0] s;
    int n;
    n = 0;
    s = '0;
    while (!s[0] && n < 20000) begin
      rd(A_CTRL, s);
      n++;
    end
    check(s[0] == 1'b1, "R9 done reached", longint'(s), 1);
  endtask

  task automatic check_rx(input int idx, input string tag);
    logic [15:0] d;
    rd(6'h20 + 6'(idx), d);
    check(d == rx_exp[idx], tag, longint'(d), longint'(rx_exp[idx]));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic [15:0] s;
    miso = miso_bit(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(sel_out == 4'hF, "R1 select lines at rest", longint'(sel_out), 4'hF);
    check(sck == 1'b0, "R1 SCK low", longint'(sck), 0);
    check(queue_done == 1'b0, "R1 done low", longint'(queue_done), 0);
    rd(A_CTRL, s);
    check(s == 16'h0, "R1 status", longint'(s), 0);

    // pattern 1: 16-bit, select held, divider 2, no pause
    wr(A_BAUD, 16'd2); wr(A_GAP, 16'd0);
    exp_half = 2; exp_gap = 2 + 2 + 0;
    push_entry(0, 16'hA5C3, 4'b0001, 1, 1, 0);
    push_entry(1, 16'h0F0F, 4'b0011, 1, 1, 1);
    push_entry(2, 16'h8001, 4'b0001, 0, 1, 1);
    wr(A_PTR, 16'h0020);
    idle_cycles = 0; seen_rise = 0;
    wr(A_CTRL, 16'h1);
    wait_done();
    check(exp_q.size() == 0, "R2 all bits sent", exp_q.size(), 0);
    check_rx(0, "R2 rx word 0");
    check_rx(1, "R2 rx word 1");
    check_rx(2, "R2 rx word 2");
    check(idle_cycles == 0, "R5 select held across entries", idle_cycles, 0);
    check(sel_out == 4'hF, "R9 lines released", longint'(sel_out), 4'hF);
    wr(A_CTRL, 16'h2);

    // pattern 2: 8-bit, select released, mixed polarity, divider 1, pause 3
    wr(A_BAUD, 16'd1); wr(A_GAP, 16'd3); wr(A_IDLE, 16'h000A);
    idle_val = 4'hA;
    @(negedge clk);
    check(sel_out == 4'hA, "R4 programmed rest levels", longint'(sel_out), 4'hA);
    exp_half = 1; exp_gap = 1 + 2 + 3;
    push_entry(3, 16'h773C, 4'b0100, 0, 0, 0);
    push_entry(4, 16'h0000, 4'b0101, 0, 0, 1);
    push_entry(5, 16'h12FF, 4'b1000, 0, 0, 1);
    wr(A_PTR, 16'h0053);
    idle_cycles = 0; seen_rise = 0;
    wr(A_CTRL, 16'h1);
    wait_done();
    check(exp_q.size() == 0, "R2 all bits sent", exp_q.size(), 0);
    check_rx(3, "R6 byte rx upper zero");
    check_rx(4, "R11 dummy word response");
    check_rx(5, "R6 byte rx");
    check(idle_cycles > 0, "R5 select released between entries", idle_cycles, 1);
    check(sel_out == 4'hA, "R9 lines released", longint'(sel_out), 4'hA);

    // pattern 3: zero divider, single zero word, repeated start
    wr(A_CTRL, 16'h2);
    wr(A_BAUD, 16'd0); wr(A_IDLE, 16'h000F);
    idle_val = 4'hF;
    exp_half = 1;
    push_entry(7, 16'h0000, 4'b0010, 1, 1, 0);
    wr(A_PTR, 16'h0077);
    rise_count = 0; seen_rise = 0;
    wr(A_CTRL, 16'h1);
    repeat (8) @(negedge clk);
    rd(A_CTRL, s);
    check(s == 16'h2, "R10 busy during transfer", longint'(s), 2);
    wr(A_CTRL, 16'h1);
    wait_done();
    repeat (60) @(negedge clk);
    check(rise_count == 16, "R10 no extra transfer", rise_count, 16);
    check(exp_q.size() == 0, "R11 zero word sent", exp_q.size(), 0);
    check_rx(7, "R11 response captured");
    rd(A_CTRL, s);
    check(s == 16'h1, "R9 done sticky", longint'(s), 1);
    check(queue_done == 1'b1, "R9 done output", longint'(queue_done), 1);
    check(sel_out == 4'hF, "R9 released despite hold bit", longint'(sel_out), 4'hF);
    wr(A_CTRL, 16'h2);
    rd(A_CTRL, s);
    check(s == 16'h0, "R9 done cleared", longint'(s), 0);
    summary();
  end
endmodule